// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit settles change-of-flow instructions while they sit in the decode stage of a five-stage in-order pipeline. It handles equal-compare branches, not-equal-compare branches and unconditional jumps. Both candidate targets are formed from the incremented PC and the instruction's immediate or index field. This happens for every instruction, at the same time as the register file is read. A target is used only when the instruction actually redirects fetch.

The two source operands are compared by a dedicated equality comparator in decode. Each operand is taken from the register file or is forwarded from the memory or write-back stage. If an operand is still being produced by the instruction in execute, or by a load in the memory stage, the unit holds decode for one cycle instead of comparing. When a branch is taken or a jump decodes, the unit steers the next-PC mux and asserts a flush. The flush zeroes the fetch/decode instruction register, which turns that instruction into a no-op. The redirect therefore costs a single bubble.

The outputs are combinational functions of the decode-stage inputs. The clock and reset serve the embedded checks only.

Top module: `brres_top`

## Requirements
- R1: An instruction with opcode 6'h04 whose two operands are equal gives pc_sel = 2'd1 and flush_ifid = 1, and redirect_pc holds the branch target. With unequal operands it gives pc_sel = 2'd0.
- R2: An instruction with opcode 6'h05 whose two operands differ gives pc_sel = 2'd1 and flush_ifid = 1, and redirect_pc holds the branch target. With equal operands it gives pc_sel = 2'd0.
- R3: A branch that is not taken gives pc_sel = 2'd0 and flush_ifid = 0, and redirect_pc equals id_pc_plus4.
- R4: The branch target is id_pc_plus4 plus the sign-extended 16-bit id_imm shifted left by two. A negative offset moves the target backwards.
- R5: Opcode 6'h02 always gives pc_sel = 2'd2 and flush_ifid = 1, and never asserts stall_id, even when a hazard matches. redirect_pc is {id_pc_plus4[31:28], id_jidx, 2'b00}.
- R6: Each compared operand is chosen in this order of priority: the memory-stage result when that stage writes a matching register and is not a load; then the write-back data when that stage writes a matching register; otherwise the register-file value.
- R7: Register index 0 is never forwarded and never causes a stall. Its operand is always the register-file value.
- R8: A branch (6'h04 or 6'h05) asserts stall_id in two cases: a source matches ex_rd with ex_regwrite set, or a source matches mem_rd with mem_regwrite and mem_is_load set. While stalled, pc_sel = 2'd0 and flush_ifid = 0.
- R9: Any other opcode gives pc_sel = 2'd0, flush_ifid = 0 and stall_id = 0, whatever the operands and hazards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_rs | input | 5 | First source register index |
| id_rt | input | 5 | Second source register index |
| id_imm | input | 16 | Branch offset in words |
| id_jidx | input | 26 | Jump word index |
| id_pc_plus4 | input | 32 | Incremented PC of the decode instruction |
| rf_rs_data | input | 32 | Register-file value for id_rs |
| rf_rt_data | input | 32 | Register-file value for id_rt |
| ex_rd | input | 5 | Destination of the instruction in execute |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | Memory-stage ALU result for forwarding |
| wb_rd | input | 5 | Destination of the write-back instruction |
| wb_regwrite | input | 1 | Write-back instruction writes a register |
| wb_data | input | 32 | Write-back value for forwarding |
| pc_sel | output | 2 | Next-PC select: 0 sequential, 1 branch, 2 jump |
| redirect_pc | output | 32 | Selected next PC |
| flush_ifid | output | 1 | Zero the fetch/decode instruction field |
| stall_id | output | 1 | Hold decode and fetch for this cycle |

## Verification
A forwarding decision and a hazard stall can fall in the same cycle. Both can also coincide with a jump that ignores them. The bench sets up several such collisions. In one, the memory stage writes a branch source as a load while the write-back stage also writes it. In another, execute targets a branch source while a second source is being forwarded. In a third, a jump decodes while every hazard input matches. In each case the bench judges which of stall, flush and redirect wins: the stall must suppress both flush and redirect for branches, and it must never appear for jumps.

// File: rtl/brres_pkg.sv
package brres_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int OPC_W  = 6;
    localparam int IMM_W  = 16;
    localparam int JIDX_W = 26;
    localparam int NSRC   = 2;
    localparam int SEG_W  = XLEN - JIDX_W - 2;

    localparam logic [OPC_W-1:0] OPC_BEQ = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE = 6'h05;
    localparam logic [OPC_W-1:0] OPC_JMP = 6'h02;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_sel_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } opnd_src_e;

    typedef struct packed {
        logic              wr;
        logic [RIDX_W-1:0] rd;
    } dest_t;

    typedef struct packed {
        logic is_beq;
        logic is_bne;
        logic is_jmp;
    } cof_t;

    function automatic cof_t decode_cof(input logic [OPC_W-1:0] opc);
        cof_t c;
        c.is_beq = (opc == OPC_BEQ);
        c.is_bne = (opc == OPC_BNE);
        c.is_jmp = (opc == OPC_JMP);
        return c;
    endfunction

    function automatic logic dest_hits(input dest_t d, input logic [RIDX_W-1:0] src);
        return d.wr && (d.rd != '0) && (d.rd == src);
    endfunction
endpackage

// File: rtl/brres_target.sv
module brres_target
    import brres_pkg::*;
(
    input  logic [XLEN-1:0]   pc_plus4,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   br_tgt,
    output logic [XLEN-1:0]   jmp_tgt
);
    localparam int EXT_W = XLEN - IMM_W - 2;

    logic [XLEN-1:0] offs;

    always_comb begin
        offs    = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt  = pc_plus4 + offs;
        jmp_tgt = {pc_plus4[XLEN-1 -: SEG_W], jidx, 2'b00};
    end
endmodule

// File: rtl/brres_fwd_mux.sv
module brres_fwd_mux
    import brres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] src,
    input  logic [XLEN-1:0]   rf_data,
    input  dest_t             mem_dst,
    input  logic              mem_load,
    input  logic [XLEN-1:0]   mem_data,
    input  dest_t             wb_dst,
    input  logic [XLEN-1:0]   wb_data,
    output logic [XLEN-1:0]   opnd,
    output opnd_src_e         sel
);
    always_comb begin
        if (dest_hits(mem_dst, src) && !mem_load) begin
            sel  = SRC_MEM;
            opnd = mem_data;
        end else if (dest_hits(wb_dst, src)) begin
            sel  = SRC_WB;
            opnd = wb_data;
        end else begin
            sel  = SRC_RF;
            opnd = rf_data;
        end
    end

    // R7
    zero_reg_rf_chk: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == SRC_RF && opnd == rf_data));

    // R6
    mem_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dst.wr && !mem_load && src != '0 && mem_dst.rd == src) |-> (opnd == mem_data));
endmodule

// File: rtl/brres_hazard.sv
module brres_hazard
    import brres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cof_t              cof,
    input  logic [RIDX_W-1:0] rs,
    input  logic [RIDX_W-1:0] rt,
    input  dest_t             ex_dst,
    input  dest_t             mem_dst,
    input  logic              mem_load,
    output logic              stall
);
    logic [NSRC-1:0] ex_hit;
    logic [NSRC-1:0] ld_hit;
    logic [RIDX_W-1:0] srcs [NSRC];

    assign srcs[0] = rs;
    assign srcs[1] = rt;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign ex_hit[i] = dest_hits(ex_dst, srcs[i]);
        assign ld_hit[i] = mem_load && dest_hits(mem_dst, srcs[i]);
    end

    assign stall = (cof.is_beq || cof.is_bne) && ((|ex_hit) || (|ld_hit));

    // R8
    stall_only_branch_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (cof.is_beq || cof.is_bne));

    // R7
    zero_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rs == '0 && rt == '0) |-> !stall);
endmodule

// File: rtl/brres_top.sv
module brres_top
    import brres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  id_opcode,
    input  logic [RIDX_W-1:0] id_rs,
    input  logic [RIDX_W-1:0] id_rt,
    input  logic [IMM_W-1:0]  id_imm,
    input  logic [JIDX_W-1:0] id_jidx,
    input  logic [XLEN-1:0]   id_pc_plus4,
    input  logic [XLEN-1:0]   rf_rs_data,
    input  logic [XLEN-1:0]   rf_rt_data,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              ex_regwrite,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic              mem_regwrite,
    input  logic              mem_is_load,
    input  logic [XLEN-1:0]   mem_result,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic              wb_regwrite,
    input  logic [XLEN-1:0]   wb_data,
    output logic [1:0]        pc_sel,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              flush_ifid,
    output logic              stall_id
);
    cof_t            cof;
    dest_t           ex_dst, mem_dst, wb_dst;
    logic [XLEN-1:0] br_tgt, jmp_tgt;
    logic [XLEN-1:0] rf_val [NSRC];
    logic [XLEN-1:0] opnd   [NSRC];
    opnd_src_e       src_sel [NSRC];
    logic [RIDX_W-1:0] src_idx [NSRC];
    logic            ops_eq, br_taken;
    npc_sel_e        sel;

    assign cof     = decode_cof(id_opcode);
    assign ex_dst  = '{wr: ex_regwrite,  rd: ex_rd};
    assign mem_dst = '{wr: mem_regwrite, rd: mem_rd};
    assign wb_dst  = '{wr: wb_regwrite,  rd: wb_rd};

    assign src_idx[0] = id_rs;
    assign src_idx[1] = id_rt;
    assign rf_val[0]  = rf_rs_data;
    assign rf_val[1]  = rf_rt_data;

    brres_target u_tgt (
        .pc_plus4 (id_pc_plus4),
        .imm      (id_imm),
        .jidx     (id_jidx),
        .br_tgt   (br_tgt),
        .jmp_tgt  (jmp_tgt)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_fwd
        brres_fwd_mux u_fwd (
            .clk      (clk),
            .rst      (rst),
            .src      (src_idx[i]),
            .rf_data  (rf_val[i]),
            .mem_dst  (mem_dst),
            .mem_load (mem_is_load),
            .mem_data (mem_result),
            .wb_dst   (wb_dst),
            .wb_data  (wb_data),
            .opnd     (opnd[i]),
            .sel      (src_sel[i])
        );
    end

    brres_hazard u_haz (
        .clk      (clk),
        .rst      (rst),
        .cof      (cof),
        .rs       (id_rs),
        .rt       (id_rt),
        .ex_dst   (ex_dst),
        .mem_dst  (mem_dst),
        .mem_load (mem_is_load),
        .stall    (stall_id)
    );

    assign ops_eq   = (opnd[0] == opnd[1]);
    assign br_taken = (cof.is_beq && ops_eq) || (cof.is_bne && !ops_eq);

    always_comb begin
        if (cof.is_jmp)
            sel = NPC_JUMP;
        else if (br_taken && !stall_id)
            sel = NPC_BRANCH;
        else
            sel = NPC_SEQ;
    end

    always_comb begin
        unique case (sel)
            NPC_BRANCH: redirect_pc = br_tgt;
            NPC_JUMP:   redirect_pc = jmp_tgt;
            default:    redirect_pc = id_pc_plus4;
        endcase
    end

    assign pc_sel     = sel;
    assign flush_ifid = (sel != NPC_SEQ);

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall_id |-> (pc_sel == NPC_SEQ && !flush_ifid));

    // R5
    jump_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (id_opcode == OPC_JMP) |-> (pc_sel == NPC_JUMP && flush_ifid && !stall_id));

    // R9
    other_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (id_opcode != OPC_JMP && id_opcode != OPC_BEQ && id_opcode != OPC_BNE)
            |-> (pc_sel == NPC_SEQ && !flush_ifid && !stall_id));

    // R3
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == NPC_SEQ) |-> (redirect_pc == id_pc_plus4 && !flush_ifid));
endmodule

// File: tb/tb_brres_top.sv
module tb_brres_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  id_opcode;
    logic [4:0]  id_rs, id_rt;
    logic [15:0] id_imm;
    logic [25:0] id_jidx;
    logic [31:0] id_pc_plus4, rf_rs_data, rf_rt_data;
    logic [4:0]  ex_rd, mem_rd, wb_rd;
    logic        ex_regwrite, mem_regwrite, mem_is_load, wb_regwrite;
    logic [31:0] mem_result, wb_data;
    logic [1:0]  pc_sel;
    logic [31:0] redirect_pc;
    logic        flush_ifid, stall_id;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    brres_top dut (
        .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_rs(id_rs), .id_rt(id_rt),
        .id_imm(id_imm), .id_jidx(id_jidx), .id_pc_plus4(id_pc_plus4),
        .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data), .ex_rd(ex_rd),
        .ex_regwrite(ex_regwrite), .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
        .mem_is_load(mem_is_load), .mem_result(mem_result), .wb_rd(wb_rd),
        .wb_regwrite(wb_regwrite), .wb_data(wb_data), .pc_sel(pc_sel),
        .redirect_pc(redirect_pc), .flush_ifid(flush_ifid), .stall_id(stall_id)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] sel,
                           input logic [31:0] pc, input logic fl, input logic st);
        #1;
        chk(req, "pc_sel", {30'd0, pc_sel}, {30'd0, sel});
        chk(req, "redirect_pc", redirect_pc, pc);
        chk(req, "flush", {31'd0, flush_ifid}, {31'd0, fl});
        chk(req, "stall", {31'd0, stall_id}, {31'd0, st});
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        id_opcode = 6'h00; id_rs = 5'd0; id_rt = 5'd0; id_imm = 16'd0; id_jidx = 26'd0;
        id_pc_plus4 = 32'h0000_1000; rf_rs_data = 32'd0; rf_rt_data = 32'd0;
        ex_rd = 5'd0; ex_regwrite = 1'b0; mem_rd = 5'd0; mem_regwrite = 1'b0;
        mem_is_load = 1'b0; mem_result = 32'd0; wb_rd = 5'd0; wb_regwrite = 1'b0;
        wb_data = 32'd0;
    endtask

    task automatic set_branch(input logic [5:0] opc, input logic [31:0] a, input logic [31:0] b,
                              input logic [15:0] imm, input logic [31:0] pc4);
        idle_inputs();
        id_opcode = opc; id_rs = 5'd1; id_rt = 5'd2;
        rf_rs_data = a; rf_rt_data = b; id_imm = imm; id_pc_plus4 = pc4;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1'b1;
        chk_out("R9 reset", 2'd0, 32'h0000_1000, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_beq();
        set_branch(6'h04, 32'h55, 32'h55, 16'h0010, 32'h0000_1000);
        chk_out("R1 beq equal", 2'd1, 32'h0000_1040, 1'b1, 1'b0);
        set_branch(6'h04, 32'h55, 32'h56, 16'h0010, 32'h0000_1000);
        chk_out("R1 R3 beq unequal", 2'd0, 32'h0000_1000, 1'b0, 1'b0);
    endtask

    task automatic t_bne();
        set_branch(6'h05, 32'h1, 32'h8000_0001, 16'h0004, 32'h0000_3000);
        chk_out("R2 bne differ", 2'd1, 32'h0000_3010, 1'b1, 1'b0);
        set_branch(6'h05, 32'h77, 32'h77, 16'h0004, 32'h0000_3000);
        chk_out("R2 R3 bne equal", 2'd0, 32'h0000_3000, 1'b0, 1'b0);
    endtask

    task automatic t_offset();
        set_branch(6'h04, 32'h9, 32'h9, 16'hFFFE, 32'h0000_2000);
        chk_out("R4 negative offset", 2'd1, 32'h0000_1FF8, 1'b1, 1'b0);
        set_branch(6'h05, 32'h0, 32'h1, 16'h7FFF, 32'h0000_0000);
        chk_out("R4 max positive offset", 2'd1, 32'h0001_FFFC, 1'b1, 1'b0);
    endtask

    task automatic t_jump();
        idle_inputs();
        id_opcode = 6'h02; id_pc_plus4 = 32'hA000_0004; id_jidx = 26'h012_3456;
        id_rs = 5'd3; id_rt = 5'd4;
        ex_rd = 5'd3; ex_regwrite = 1'b1;
        mem_rd = 5'd4; mem_regwrite = 1'b1; mem_is_load = 1'b1;
        chk_out("R5 jump with hazards", 2'd2, 32'hA048_D158, 1'b1, 1'b0);
    endtask

    task automatic t_forward();
        set_branch(6'h04, 32'h11, 32'h22, 16'h0001, 32'h0000_4000);
        mem_rd = 5'd2; mem_regwrite = 1'b1; mem_result = 32'h11;
        chk_out("R6 mem forward", 2'd1, 32'h0000_4004, 1'b1, 1'b0);
        wb_rd = 5'd2; wb_regwrite = 1'b1; wb_data = 32'h22;
        chk_out("R6 mem over wb", 2'd1, 32'h0000_4004, 1'b1, 1'b0);
        set_branch(6'h04, 32'h11, 32'h22, 16'h0001, 32'h0000_4000);
        wb_rd = 5'd2; wb_regwrite = 1'b1; wb_data = 32'h11;
        chk_out("R6 wb forward", 2'd1, 32'h0000_4004, 1'b1, 1'b0);
        set_branch(6'h04, 32'h11, 32'h11, 16'h0001, 32'h0000_4000);
        mem_rd = 5'd1; mem_regwrite = 1'b0; mem_result = 32'h99;
        chk_out("R6 no write no forward", 2'd1, 32'h0000_4004, 1'b1, 1'b0);
    endtask

    task automatic t_zero_reg();
        idle_inputs();
        id_opcode = 6'h04; id_rs = 5'd0; id_rt = 5'd0; id_imm = 16'h0002;
        mem_rd = 5'd0; mem_regwrite = 1'b1; mem_result = 32'h5;
        wb_rd = 5'd0; wb_regwrite = 1'b1; wb_data = 32'h6;
        ex_rd = 5'd0; ex_regwrite = 1'b1;
        chk_out("R7 zero reg", 2'd1, 32'h0000_1008, 1'b1, 1'b0);
    endtask

    task automatic t_stall();
        set_branch(6'h04, 32'h3, 32'h3, 16'h0010, 32'h0000_5000);
        ex_rd = 5'd1; ex_regwrite = 1'b1;
        mem_rd = 5'd2; mem_regwrite = 1'b1; mem_result = 32'h3;
        chk_out("R8 ex hazard", 2'd0, 32'h0000_5000, 1'b0, 1'b1);
        set_branch(6'h05, 32'h3, 32'h4, 16'h0010, 32'h0000_5000);
        mem_rd = 5'd2; mem_regwrite = 1'b1; mem_is_load = 1'b1; mem_result = 32'h3;
        wb_rd = 5'd2; wb_regwrite = 1'b1; wb_data = 32'h3;
        chk_out("R8 load hazard", 2'd0, 32'h0000_5000, 1'b0, 1'b1);
        set_branch(6'h05, 32'h3, 32'h4, 16'h0010, 32'h0000_5000);
        mem_rd = 5'd2; mem_regwrite = 1'b1; mem_is_load = 1'b0; mem_result = 32'h5;
        chk_out("R8 R6 alu in mem no stall", 2'd1, 32'h0000_5040, 1'b1, 1'b0);
        set_branch(6'h04, 32'h3, 32'h3, 16'h0010, 32'h0000_5000);
        ex_rd = 5'd7; ex_regwrite = 1'b1;
        chk_out("R8 unrelated ex dest", 2'd1, 32'h0000_5040, 1'b1, 1'b0);
    endtask

    task automatic t_other();
        set_branch(6'h23, 32'h3, 32'h3, 16'h0010, 32'h0000_6000);
        ex_rd = 5'd1; ex_regwrite = 1'b1;
        chk_out("R9 other opcode", 2'd0, 32'h0000_6000, 1'b0, 1'b0);
        set_branch(6'h03, 32'h3, 32'h4, 16'h0010, 32'h0000_6000);
        chk_out("R9 near-jump opcode", 2'd0, 32'h0000_6000, 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_beq();
        t_bne();
        t_offset();
        t_jump();
        t_forward();
        t_zero_reg();
        t_stall();
        t_other();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule